// File: doc/BRIEF.md
# SMM Halt and I/O Restart Controller

This block holds the restart state that a processor core needs around system management mode. When the core takes a management interrupt, the block records whether the core was sitting in a halt. It clears the I/O re-execute slot. It also latches a 32-bit I/O trap word built from sideband inputs: the port address, whether the trapping instruction was a genuine I/O instruction, and the access direction.

While the core is in management mode, the handler reads and rewrites two slots through a small register port. The halt slot holds one live bit. The I/O restart slot holds one byte.

When the handler asks to resume, the block combines the halt state captured at entry with the two slot values as they stand. From these it issues one registered, one-hot resume action for a single cycle. The four actions are:
- continue with the next instruction,
- continue after the halt,
- re-enter the halt,
- re-run the trapped I/O instruction.

Combinations with no defined outcome raise an error flag and fall back to the next-instruction action. A management interrupt that arrives directly after a resume gets no valid trap indication.

Top module: `smm_restart_ctl`

## Requirements
- R1: After reset, `in_smm`, `act_valid` and `act_error` are 0, and `act_onehot` and `trap_word` are all zeros.
- R2: An `entry_req` while out of management mode sets `in_smm` at the next edge. It stores `core_halted` into halt-slot bit 0; halt-slot bits 15..1 always read 0. An `entry_req` while already in management mode is ignored.
- R3: Every accepted entry resets the I/O restart slot to 00h.
- R4: At entry, `trap_word` is loaded as follows: bits 31..16 hold the port address, bits 15..2 are 0, bit 1 is the valid-I/O flag, and bit 0 is the direction (1 read, 0 write). When the valid flag is 0, the whole word is 0.
- R5: An entry accepted in the cycle `act_valid` is high, or in the cycle after it, is back-to-back. Such an entry loads a zero trap word, and a later 0FFh in the I/O slot is treated as an error.
- R6: The register port works as follows. `reg_sel`=0 selects the halt slot (bit 0 stored). `reg_sel`=1 selects the I/O slot (bits 7..0 stored, upper bits read 0). `reg_rdata` follows `reg_sel` combinationally. Writes take effect only in management mode and are otherwise ignored.
- R7: A `resume_req` in management mode clears `in_smm` at the next edge and drives `act_valid` high for exactly one cycle. At the same time `act_onehot` has exactly one bit set: bit0 next instruction, bit1 after halt, bit2 re-enter halt, bit3 re-run I/O. `act_onehot` is 0 when `act_valid` is low. A `resume_req` out of management mode is ignored.
- R8: With the I/O slot at 00h, the halt action depends on the halt state at entry and the halt slot at resume. Entry 1 and slot 1 give re-enter halt. Entry 1 and slot 0 give after halt. Entry 0 and slot 0 give next instruction.
- R9: An I/O slot of 0FFh, with the entry taken on an I/O boundary and not back-to-back, gives re-run I/O. This takes precedence over the halt slot.
- R10: Three cases are undefined: halt state 0 at entry with slot 1 at resume; any I/O slot value other than 00h or 0FFh; and 0FFh with no valid I/O boundary. In these cases the block drives `act_error` with the next-instruction action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_req | input | 1 | Management interrupt entry request |
| core_halted | input | 1 | Core was halted when interrupted |
| io_boundary | input | 1 | Interrupt taken on an I/O instruction boundary |
| trap_addr | input | 16 | I/O port address of the trapped access |
| trap_valid_io | input | 1 | Trapping instruction was a real I/O instruction |
| trap_is_read | input | 1 | Trapped access direction, 1 read |
| resume_req | input | 1 | Handler requests return from management mode |
| reg_wr | input | 1 | Handler register write strobe |
| reg_sel | input | 1 | 0 halt slot, 1 I/O restart slot |
| reg_wdata | input | 16 | Handler write data |
| reg_rdata | output | 16 | Selected slot read data |
| in_smm | output | 1 | Block is in management mode |
| trap_word | output | 32 | Latched I/O trap word |
| act_valid | output | 1 | Resume action strobe |
| act_onehot | output | 4 | One-hot resume action |
| act_error | output | 1 | Undefined restart combination |

## Verification
The resume decision is exercised with every pairing of halt state at entry and halt slot at resume. This separates re-entering the halt, continuing after it, and a plain return, and it shows that the one forbidden pairing is flagged. The I/O slot is driven with 00h, 0FFh and a stray byte, on and off an I/O boundary. This shows that re-run wins over the halt slot and that only 0FFh on a true boundary is accepted. Entries are placed in the action cycle, one cycle later and two cycles later, to locate the edge of the back-to-back window through the trap word. Writes and resume requests issued outside management mode, and a second entry request inside it, are checked for having no effect on the slots or outputs.

// File: rtl/smm_rst_pkg.sv
package smm_rst_pkg;
  typedef enum logic [3:0] {
    ACT_NONE         = 4'b0000,
    ACT_NEXT         = 4'b0001,
    ACT_AFTER_HALT   = 4'b0010,
    ACT_REENTER_HALT = 4'b0100,
    ACT_IO_RERUN     = 4'b1000
  } resume_act_e;
endpackage

// File: rtl/smm_slot_regs.sv
module smm_slot_regs #(
  parameter int SLOT_W    = 16,
  parameter int IO_SLOT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 entry_go,
  input  logic                 core_halted,
  input  logic                 wr_en,
  input  logic                 reg_sel,
  input  logic [SLOT_W-1:0]    reg_wdata,
  output logic                 halt_bit,
  output logic [IO_SLOT_W-1:0] io_slot,
  output logic [SLOT_W-1:0]    rdata
);
  localparam int IO_PAD_W   = SLOT_W - IO_SLOT_W;
  localparam int HALT_PAD_W = SLOT_W - 1;

  logic                 halt_d;
  logic [IO_SLOT_W-1:0] io_d;
  logic                 halt_en;
  logic                 io_en;

  always_comb begin
    halt_en = 1'b0;
    io_en   = 1'b0;
    halt_d  = halt_bit;
    io_d    = io_slot;
    if (entry_go) begin
      halt_en = 1'b1;
      io_en   = 1'b1;
      halt_d  = core_halted;
      io_d    = '0;
    end else if (wr_en) begin
      if (reg_sel) begin
        io_en = 1'b1;
        io_d  = reg_wdata[IO_SLOT_W-1:0];
      end else begin
        halt_en = 1'b1;
        halt_d  = reg_wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_bit <= 1'b0;
      io_slot  <= '0;
    end else begin
      if (halt_en) halt_bit <= halt_d;
      if (io_en)   io_slot  <= io_d;
    end
  end

  always_comb begin
    if (reg_sel) rdata = {{IO_PAD_W{1'b0}}, io_slot};
    else         rdata = {{HALT_PAD_W{1'b0}}, halt_bit};
  end
endmodule

// File: rtl/smm_trap_capture.sv
module smm_trap_capture #(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 entry_go,
  input  logic                 back_to_back,
  input  logic [ADDR_W-1:0]    trap_addr,
  input  logic                 trap_valid_io,
  input  logic                 trap_is_read,
  output logic [ADDR_W+15:0]   trap_word
);
  localparam int TRAP_W = ADDR_W + 16;
  localparam int RSV_W  = TRAP_W - ADDR_W - 2;

  logic              word_valid;
  logic [TRAP_W-1:0] word_d;

  always_comb begin
    word_valid = trap_valid_io & ~back_to_back;
    if (word_valid) word_d = {trap_addr, {RSV_W{1'b0}}, 1'b1, trap_is_read};
    else            word_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trap_word <= '0;
    else if (entry_go) trap_word <= word_d;
  end
endmodule

// File: rtl/smm_resume_decide.sv
module smm_resume_decide
  import smm_rst_pkg::*;
#(
  parameter int IO_SLOT_W = 8
) (
  input  logic                 entry_halt,
  input  logic                 halt_bit,
  input  logic [IO_SLOT_W-1:0] io_slot,
  input  logic                 io_ok,
  output resume_act_e          action,
  output logic                 undefined
);
  logic io_rerun;
  logic io_none;
  logic halt_bad;
  logic io_bad;

  always_comb begin
    io_rerun  = (io_slot == {IO_SLOT_W{1'b1}});
    io_none   = (io_slot == '0);
    halt_bad  = ~entry_halt & halt_bit;
    io_bad    = (~io_rerun & ~io_none) | (io_rerun & ~io_ok);
    undefined = halt_bad | io_bad;
    if (undefined)                  action = ACT_NEXT;
    else if (io_rerun)              action = ACT_IO_RERUN;
    else if (entry_halt & halt_bit) action = ACT_REENTER_HALT;
    else if (entry_halt)            action = ACT_AFTER_HALT;
    else                            action = ACT_NEXT;
  end
endmodule

// File: rtl/smm_restart_ctl.sv
module smm_restart_ctl
  import smm_rst_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SLOT_W    = 16,
  parameter int IO_SLOT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 entry_req,
  input  logic                 core_halted,
  input  logic                 io_boundary,
  input  logic [ADDR_W-1:0]    trap_addr,
  input  logic                 trap_valid_io,
  input  logic                 trap_is_read,
  input  logic                 resume_req,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [SLOT_W-1:0]    reg_wdata,
  output logic [SLOT_W-1:0]    reg_rdata,
  output logic                 in_smm,
  output logic [ADDR_W+15:0]   trap_word,
  output logic                 act_valid,
  output logic [3:0]           act_onehot,
  output logic                 act_error
);
  logic                 entry_go;
  logic                 resume_go;
  logic                 back_to_back;
  logic                 act_seen_q;
  logic                 entry_halt_q;
  logic                 io_ok_q;
  logic                 halt_bit;
  logic [IO_SLOT_W-1:0] io_slot;
  resume_act_e          dec_action;
  logic                 dec_undef;

  logic                 in_smm_d;
  logic                 act_valid_d;
  logic [3:0]           act_onehot_d;
  logic                 act_error_d;

  assign entry_go     = entry_req & ~in_smm;
  assign resume_go    = resume_req & in_smm;
  assign back_to_back = act_valid | act_seen_q;

  smm_slot_regs #(.SLOT_W(SLOT_W), .IO_SLOT_W(IO_SLOT_W)) u_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_go    (entry_go),
    .core_halted (core_halted),
    .wr_en       (reg_wr & in_smm),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .halt_bit    (halt_bit),
    .io_slot     (io_slot),
    .rdata       (reg_rdata)
  );

  smm_trap_capture #(.ADDR_W(ADDR_W)) u_trap (
    .clk           (clk),
    .rst_n         (rst_n),
    .entry_go      (entry_go),
    .back_to_back  (back_to_back),
    .trap_addr     (trap_addr),
    .trap_valid_io (trap_valid_io),
    .trap_is_read  (trap_is_read),
    .trap_word     (trap_word)
  );

  smm_resume_decide #(.IO_SLOT_W(IO_SLOT_W)) u_decide (
    .entry_halt (entry_halt_q),
    .halt_bit   (halt_bit),
    .io_slot    (io_slot),
    .io_ok      (io_ok_q),
    .action     (dec_action),
    .undefined  (dec_undef)
  );

  always_comb begin
    in_smm_d     = in_smm;
    act_valid_d  = 1'b0;
    act_onehot_d = ACT_NONE;
    act_error_d  = 1'b0;
    if (entry_go) begin
      in_smm_d = 1'b1;
    end else if (resume_go) begin
      in_smm_d     = 1'b0;
      act_valid_d  = 1'b1;
      act_onehot_d = dec_action;
      act_error_d  = dec_undef;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_smm     <= 1'b0;
      act_valid  <= 1'b0;
      act_onehot <= '0;
      act_error  <= 1'b0;
      act_seen_q <= 1'b0;
    end else begin
      in_smm     <= in_smm_d;
      act_valid  <= act_valid_d;
      act_onehot <= act_onehot_d;
      act_error  <= act_error_d;
      act_seen_q <= act_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_halt_q <= 1'b0;
      io_ok_q      <= 1'b0;
    end else if (entry_go) begin
      entry_halt_q <= core_halted;
      io_ok_q      <= io_boundary & ~back_to_back;
    end
  end
endmodule

// File: rtl/smm_restart_chk.sv
module smm_restart_chk #(
  parameter int ADDR_W    = 16,
  parameter int IO_SLOT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 entry_go,
  input logic                 resume_go,
  input logic                 back_to_back,
  input logic                 in_smm,
  input logic                 halt_bit,
  input logic [IO_SLOT_W-1:0] io_slot,
  input logic [ADDR_W+15:0]   trap_word,
  input logic                 act_valid,
  input logic [3:0]           act_onehot,
  input logic                 act_error
);
  AST_ENTRY_SETS: assert property (@(posedge clk) disable iff (!rst_n) entry_go |=> in_smm); // R2
  AST_IO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) entry_go |=> io_slot == '0); // R3
  AST_TRAP_RSV: assert property (@(posedge clk) disable iff (!rst_n) trap_word[15:2] == '0); // R4
  AST_TRAP_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !trap_word[1] |-> trap_word == '0); // R4
  AST_B2B_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n) (entry_go && back_to_back) |=> !trap_word[1]); // R5
  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (!in_smm && !entry_go) |=> ($stable(halt_bit) && $stable(io_slot))); // R6
  AST_RESUME_STROBE: assert property (@(posedge clk) disable iff (!rst_n) resume_go |=> (act_valid && !in_smm)); // R7
  AST_ACT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) act_valid |=> !act_valid); // R7
  AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) act_valid |-> $countones(act_onehot) == 1); // R7
  AST_ACT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !act_valid |-> (act_onehot == 4'b0000 && !act_error)); // R7
  AST_ERR_NEXT: assert property (@(posedge clk) disable iff (!rst_n) act_error |-> act_onehot == 4'b0001); // R10
endmodule

bind smm_restart_ctl smm_restart_chk #(.ADDR_W(ADDR_W), .IO_SLOT_W(IO_SLOT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .entry_go     (entry_go),
  .resume_go    (resume_go),
  .back_to_back (back_to_back),
  .in_smm       (in_smm),
  .halt_bit     (halt_bit),
  .io_slot      (io_slot),
  .trap_word    (trap_word),
  .act_valid    (act_valid),
  .act_onehot   (act_onehot),
  .act_error    (act_error)
);

// File: tb/sim_smm_restart_ctl.sv
module sim_smm_restart_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry_req = 1'b0, core_halted = 1'b0, io_boundary = 1'b0;
  logic [15:0] trap_addr = '0;
  logic        trap_valid_io = 1'b0, trap_is_read = 1'b0;
  logic        resume_req = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        in_smm;
  logic [31:0] trap_word;
  logic        act_valid;
  logic [3:0]  act_onehot;
  logic        act_error;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] A_NEXT = 4'b0001, A_AFTER = 4'b0010, A_REENTER = 4'b0100, A_IO = 4'b1000;

  always #5 clk = ~clk;

  smm_restart_ctl u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enter(logic h, logic iob, logic [15:0] a, logic v, logic rd);
    core_halted = h; io_boundary = iob; trap_addr = a; trap_valid_io = v; trap_is_read = rd;
    entry_req = 1'b1;
    @(negedge clk);
    entry_req = 1'b0;
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic sel, output logic [15:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic resume(string req, logic [3:0] exp_a, logic exp_e);
    resume_req = 1'b1;
    @(negedge clk);
    resume_req = 1'b0;
    chk(req, {31'd0, act_valid}, 32'd1);
    chk(req, {28'd0, act_onehot}, {28'd0, exp_a});
    chk(req, {31'd0, act_error}, {31'd0, exp_e});
    chk(req, {31'd0, in_smm}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 in_smm", {31'd0, in_smm}, 32'd0);
    chk("R1 act_valid", {31'd0, act_valid}, 32'd0);
    chk("R1 act_onehot", {28'd0, act_onehot}, 32'd0);
    chk("R1 act_error", {31'd0, act_error}, 32'd0);
    chk("R1 trap_word", trap_word, 32'd0);
  endtask

  task automatic t_halt_combos();
    logic [15:0] d;
    enter(1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
    chk("R2 in_smm", {31'd0, in_smm}, 32'd1);
    rd(1'b0, d);
    chk("R2 halt slot", {16'd0, d}, 32'd1);
    resume("R8 1/1 reenter", A_REENTER, 1'b0);
    @(negedge clk); @(negedge clk);
    enter(1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
    wr(1'b0, 16'hFFFE);
    rd(1'b0, d);
    chk("R6 halt write", {16'd0, d}, 32'd0);
    resume("R8 1/0 after halt", A_AFTER, 1'b0);
    @(negedge clk); @(negedge clk);
    enter(1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    rd(1'b0, d);
    chk("R2 halt slot 0", {16'd0, d}, 32'd0);
    resume("R8 0/0 next", A_NEXT, 1'b0);
    @(negedge clk); @(negedge clk);
    enter(1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    wr(1'b0, 16'h0001);
    resume("R10 halt 0/1", A_NEXT, 1'b1);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_io();
    logic [15:0] d;
    enter(1'b0, 1'b1, 16'h03F8, 1'b1, 1'b1);
    chk("R4 trap read", trap_word, 32'h03F8_0003);
    rd(1'b1, d);
    chk("R3 io slot clear", {16'd0, d}, 32'd0);
    wr(1'b1, 16'hABFF);
    rd(1'b1, d);
    chk("R6 io slot width", {16'd0, d}, 32'h00FF);
    resume("R9 io rerun", A_IO, 1'b0);
    @(negedge clk); @(negedge clk);
    enter(1'b1, 1'b1, 16'h0070, 1'b1, 1'b0);
    chk("R4 trap write", trap_word, 32'h0070_0002);
    rd(1'b1, d);
    chk("R3 io slot clear again", {16'd0, d}, 32'd0);
    wr(1'b1, 16'h00FF);
    resume("R9 io beats halt", A_IO, 1'b0);
    @(negedge clk); @(negedge clk);
    enter(1'b0, 1'b1, 16'h0060, 1'b1, 1'b1);
    wr(1'b1, 16'h005A);
    resume("R10 stray io byte", A_NEXT, 1'b1);
    @(negedge clk); @(negedge clk);
    enter(1'b0, 1'b0, 16'h0060, 1'b1, 1'b1);
    wr(1'b1, 16'h00FF);
    resume("R10 FF off boundary", A_NEXT, 1'b1);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_trap_invalid();
    enter(1'b0, 1'b1, 16'h1234, 1'b0, 1'b1);
    chk("R4 invalid zero", trap_word, 32'd0);
    resume("R8 plain return", A_NEXT, 1'b0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_ignore();
    logic [15:0] d;
    wr(1'b0, 16'h0001);
    rd(1'b0, d);
    chk("R6 halt write outside", {16'd0, d}, 32'd0);
    wr(1'b1, 16'h00FF);
    rd(1'b1, d);
    chk("R6 io write outside", {16'd0, d}, 32'd0);
    resume_req = 1'b1;
    @(negedge clk);
    resume_req = 1'b0;
    chk("R7 resume outside", {31'd0, act_valid}, 32'd0);
    enter(1'b0, 1'b1, 16'h0040, 1'b1, 1'b0);
    enter(1'b1, 1'b1, 16'h0041, 1'b1, 1'b1);
    rd(1'b0, d);
    chk("R2 second entry ignored halt", {16'd0, d}, 32'd0);
    chk("R2 second entry ignored trap", trap_word, 32'h0040_0002);
    resume("R8 after ignored entry", A_NEXT, 1'b0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_b2b();
    enter(1'b0, 1'b1, 16'h0080, 1'b1, 1'b1);
    resume("R7 b2b first", A_NEXT, 1'b0);
    enter(1'b0, 1'b1, 16'h0060, 1'b1, 1'b1);
    chk("R5 b2b same cycle trap", trap_word, 32'd0);
    wr(1'b1, 16'h00FF);
    resume("R5 b2b FF error", A_NEXT, 1'b1);
    @(negedge clk);
    enter(1'b0, 1'b1, 16'h0061, 1'b1, 1'b0);
    chk("R5 b2b next cycle trap", trap_word, 32'd0);
    resume("R5 b2b next cycle resume", A_NEXT, 1'b0);
    @(negedge clk); @(negedge clk);
    enter(1'b0, 1'b1, 16'h0062, 1'b1, 1'b0);
    chk("R5 outside window trap", trap_word, 32'h0062_0002);
    wr(1'b1, 16'h00FF);
    resume("R9 outside window rerun", A_IO, 1'b0);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt_combos();
    t_io();
    t_trap_invalid();
    t_ignore();
    t_b2b();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule